// File: doc/BRIEF.md
# Next-Hop Adjacency Resolver

This block sits after a prefix lookup. It takes the adjacency index that the lookup returns, reads a small table of adjacency entries, and decides what becomes of the packet. Each entry holds a typed disposition, an output interface number, a prebuilt layer-2 rewrite header, and a flag that says whether the next hop is on a point-to-point link. The result, one cycle after the request, gives the disposition code, a transmit flag, the interface, the rewrite header and its length in bytes.

For every lookup, the entry's packet counter and byte counter advance. Both counters stop at all-ones and never wrap. A select input reads the counters of any entry at any time. When a lookup lands on the single glean entry, the block pulses an address-resolution request that carries the index, so that a neighbour can send the request. A host write port changes one entry at a time. Moving a next hop therefore touches only its adjacency entry, and the prefix leaves that point to that entry stay as they are.

Top module: `adj_resolver`

## Requirements
- R1: After reset, and for any index never written, a lookup returns disposition drop with res_tx=0, res_ifc=0, res_hdr=0 and res_hdr_len=0.
- R2: A forward entry (code 1) returns res_tx=1 with the stored interface and header. res_hdr_len is 14 when the entry's cfg_p2p was 0 (Ethernet next hop) and 4 when it was 1 (point-to-point next hop).
- R3: A punt entry (code 2) returns code 2 with res_tx=0, so the packet goes to the next slower switching path.
- R4: A lookup on a glean entry (code 3) sets arp_req high for the single cycle of its result, with arp_idx equal to the index looked up. No other code ever raises arp_req.
- R5: At most one entry holds the glean code. A glean write to another index while a glean entry exists is ignored completely: the entry and its counters stay unchanged. Writing a non-glean code over the glean entry frees the glean slot.
- R6: Drop (0), discard (4), null (5) and receive (6) entries each return their own code with res_tx=0 and with interface, header and length all zero.
- R7: Disposition codes are 3 bits: 0 drop, 1 forward, 2 punt, 3 glean, 4 discard, 5 null, 6 receive. A write of code 7 is stored as drop.
- R8: res_valid is high exactly in the cycle after a cycle with lk_valid high, and the result in that cycle belongs to that request.
- R9: Each lookup adds 1 to the entry's packet count and lk_len to its byte count. cnt_pkts and cnt_bytes show the counts of the entry picked by cnt_sel, without delay.
- R10: The packet and byte counters hold at all-ones and never wrap. A byte sum that would pass all-ones is clamped to all-ones.
- R11: An accepted write replaces the entry, clears its two counters, and changes no other entry or counter. The next lookup of that index returns the new contents.
- R12: When a write and a lookup hit the same index in the same cycle, the lookup returns the old contents and the counters end at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Entry write strobe |
| cfg_idx | input | IDX_W | Entry to write |
| cfg_kind | input | 3 | Disposition code to store |
| cfg_p2p | input | 1 | 1: point-to-point next hop, 0: Ethernet next hop |
| cfg_ifc | input | IFC_W | Output interface number |
| cfg_hdr | input | 8*HDR_MAX | Layer-2 rewrite header |
| lk_valid | input | 1 | Lookup request |
| lk_idx | input | IDX_W | Adjacency index from the prefix lookup |
| lk_len | input | PLEN_W | Packet length in bytes |
| res_valid | output | 1 | Result valid |
| res_kind | output | 3 | Disposition code |
| res_tx | output | 1 | Packet is to be transmitted |
| res_ifc | output | IFC_W | Output interface |
| res_hdr | output | 8*HDR_MAX | Rewrite header |
| res_hdr_len | output | HLEN_W | Rewrite header length in bytes |
| arp_req | output | 1 | Address-resolution request strobe |
| arp_idx | output | IDX_W | Index of the glean entry that fired |
| cnt_sel | input | IDX_W | Entry whose counters are read |
| cnt_pkts | output | PKT_CW | Packet count of the selected entry |
| cnt_bytes | output | BYTE_CW | Byte count of the selected entry |

## Verification
Lookups are run against entries of every disposition code, against forward entries on both link types, and against indices that were never written. This tells the transmit case apart from the six non-transmit cases, and the 14-byte header length apart from the 4-byte one. Glean writes are sent to a second index while the first glean entry is still present, and again after that entry has been overwritten. This separates a rejected write from an accepted one. Repeated lookups on one index with large lengths push the counters past their limits, which shows clamping apart from wrap-around. A write and a lookup on the same index in the same cycle show which of the two wins for the result and which wins for the counters.

// File: rtl/adj_resolver.sv
module adj_resolver #(
  parameter int N_ADJ   = 16,
  parameter int IFC_W   = 5,
  parameter int HDR_MAX = 14,
  parameter int HDR_P2P = 4,
  parameter int PLEN_W  = 16,
  parameter int PKT_CW  = 32,
  parameter int BYTE_CW = 48,
  localparam int IDX_W  = $clog2(N_ADJ),
  localparam int HDR_W  = 8 * HDR_MAX,
  localparam int HLEN_W = $clog2(HDR_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [2:0]         cfg_kind,
  input  logic               cfg_p2p,
  input  logic [IFC_W-1:0]   cfg_ifc,
  input  logic [HDR_W-1:0]   cfg_hdr,
  input  logic               lk_valid,
  input  logic [IDX_W-1:0]   lk_idx,
  input  logic [PLEN_W-1:0]  lk_len,
  output logic               res_valid,
  output logic [2:0]         res_kind,
  output logic               res_tx,
  output logic [IFC_W-1:0]   res_ifc,
  output logic [HDR_W-1:0]   res_hdr,
  output logic [HLEN_W-1:0]  res_hdr_len,
  output logic               arp_req,
  output logic [IDX_W-1:0]   arp_idx,
  input  logic [IDX_W-1:0]   cnt_sel,
  output logic [PKT_CW-1:0]  cnt_pkts,
  output logic [BYTE_CW-1:0] cnt_bytes
);

  localparam logic [2:0] K_DROP  = 3'd0;
  localparam logic [2:0] K_FWD   = 3'd1;
  localparam logic [2:0] K_GLEAN = 3'd3;
  localparam logic [2:0] K_BAD   = 3'd7;
  localparam int SUM_W = ((BYTE_CW > PLEN_W) ? BYTE_CW : PLEN_W) + 1;
  localparam logic [SUM_W-1:0] BYTE_TOP = SUM_W'({BYTE_CW{1'b1}});
  localparam logic [HLEN_W-1:0] LEN_ETH = HLEN_W'(HDR_MAX);
  localparam logic [HLEN_W-1:0] LEN_PTP = HLEN_W'(HDR_P2P);

  logic [2:0]         kind_q [N_ADJ];
  logic               p2p_q  [N_ADJ];
  logic [IFC_W-1:0]   ifc_q  [N_ADJ];
  logic [HDR_W-1:0]   hdr_q  [N_ADJ];
  logic [PKT_CW-1:0]  pkt_q  [N_ADJ];
  logic [BYTE_CW-1:0] byte_q [N_ADJ];

  logic             glean_own;
  logic [IDX_W-1:0] glean_at;

  wire clash  = (cfg_kind == K_GLEAN) && glean_own && (glean_at != cfg_idx);
  wire wr_ok  = cfg_we && !clash;
  wire [2:0] wr_kind = (cfg_kind == K_BAD) ? K_DROP : cfg_kind;

  wire [2:0]        lk_kind = kind_q[lk_idx];
  wire              lk_fwd  = (lk_kind == K_FWD);
  wire [PKT_CW-1:0] pkt_cur = pkt_q[lk_idx];
  wire [PKT_CW-1:0] pkt_nxt = (&pkt_cur) ? pkt_cur : pkt_cur + 1'b1;
  wire [SUM_W-1:0]  byte_sum = SUM_W'(byte_q[lk_idx]) + SUM_W'(lk_len);
  wire [BYTE_CW-1:0] byte_nxt = (byte_sum > BYTE_TOP) ? {BYTE_CW{1'b1}}
                                                       : byte_sum[BYTE_CW-1:0];

  assign cnt_pkts  = pkt_q[cnt_sel];
  assign cnt_bytes = byte_q[cnt_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ADJ; i++) begin
        kind_q[i] <= K_DROP;
        p2p_q[i]  <= 1'b0;
        ifc_q[i]  <= '0;
        hdr_q[i]  <= '0;
        pkt_q[i]  <= '0;
        byte_q[i] <= '0;
      end
      glean_own <= 1'b0;
      glean_at  <= '0;
    end else begin
      if (lk_valid) begin
        pkt_q[lk_idx]  <= pkt_nxt;
        byte_q[lk_idx] <= byte_nxt;
      end
      if (wr_ok) begin
        kind_q[cfg_idx] <= wr_kind;
        p2p_q[cfg_idx]  <= cfg_p2p;
        ifc_q[cfg_idx]  <= cfg_ifc;
        hdr_q[cfg_idx]  <= cfg_hdr;
        pkt_q[cfg_idx]  <= '0;
        byte_q[cfg_idx] <= '0;
        if (wr_kind == K_GLEAN) begin
          glean_own <= 1'b1;
          glean_at  <= cfg_idx;
        end else if (glean_own && glean_at == cfg_idx) begin
          glean_own <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_kind    <= K_DROP;
      res_tx      <= 1'b0;
      res_ifc     <= '0;
      res_hdr     <= '0;
      res_hdr_len <= '0;
      arp_req     <= 1'b0;
      arp_idx     <= '0;
    end else begin
      res_valid <= lk_valid;
      arp_req   <= lk_valid && (lk_kind == K_GLEAN);
      if (lk_valid) begin
        res_kind    <= lk_kind;
        res_tx      <= lk_fwd;
        res_ifc     <= lk_fwd ? ifc_q[lk_idx] : '0;
        res_hdr     <= lk_fwd ? hdr_q[lk_idx] : '0;
        res_hdr_len <= !lk_fwd ? '0 : (p2p_q[lk_idx] ? LEN_PTP : LEN_ETH);
        arp_idx     <= lk_idx;
      end
    end
  end

  logic [N_ADJ-1:0] glean_map;
  always_comb
    for (int i = 0; i < N_ADJ; i++) glean_map[i] = (kind_q[i] == K_GLEAN);

  p_follows_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !res_valid);
  p_arp_glean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    arp_req |-> (res_valid && res_kind == K_GLEAN));
  p_one_glean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(glean_map) <= 1);
  p_fwd_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_tx) |-> (res_hdr_len == LEN_ETH || res_hdr_len == LEN_PTP));
  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind != K_FWD) |-> (!res_tx && res_ifc == '0 && res_hdr_len == '0));
  p_pkt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && (&pkt_q[lk_idx]) && !(cfg_we && cfg_idx == lk_idx))
      |=> (&pkt_q[$past(lk_idx)]));

endmodule

// File: tb/adj_resolver_tb.sv
module adj_resolver_tb_top;
  localparam int N = 8, IW = 3, FW = 5, HM = 14, HW = 8 * HM, LW = 16, PC = 4, BC = 10;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic cfg_we = 0, cfg_p2p = 0, lk_valid = 0;
  logic [IW-1:0] cfg_idx = 0, lk_idx = 0, cnt_sel = 0, arp_idx;
  logic [2:0] cfg_kind = 0, res_kind;
  logic [FW-1:0] cfg_ifc = 0, res_ifc;
  logic [HW-1:0] cfg_hdr = 0, res_hdr;
  logic [LW-1:0] lk_len = 0;
  logic res_valid, res_tx, arp_req;
  logic [3:0] res_hdr_len;
  logic [PC-1:0] cnt_pkts;
  logic [BC-1:0] cnt_bytes;

  adj_resolver #(.N_ADJ(N), .IFC_W(FW), .HDR_MAX(HM), .HDR_P2P(4), .PLEN_W(LW),
                 .PKT_CW(PC), .BYTE_CW(BC)) dut_i (
    .clk, .rst_n, .cfg_we, .cfg_idx, .cfg_kind, .cfg_p2p, .cfg_ifc, .cfg_hdr,
    .lk_valid, .lk_idx, .lk_len, .res_valid, .res_kind, .res_tx, .res_ifc,
    .res_hdr, .res_hdr_len, .arp_req, .arp_idx, .cnt_sel, .cnt_pkts, .cnt_bytes);

  int n_chk = 0, n_fail = 0;
  localparam logic [HW-1:0] HA = {7{16'hA55A}};
  localparam logic [HW-1:0] HB = {7{16'h1234}};
  localparam logic [HW-1:0] HC = {7{16'h0F0F}};

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [2:0] k, input logic p, input int ifc,
                    input logic [HW-1:0] h);
    @(negedge clk);
    cfg_we = 1; cfg_idx = IW'(idx); cfg_kind = k; cfg_p2p = p; cfg_ifc = FW'(ifc); cfg_hdr = h;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic look(input int idx, input int len);
    @(negedge clk);
    lk_valid = 1; lk_idx = IW'(idx); lk_len = LW'(len);
    @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic counts(input int idx, output int p, output int b);
    cnt_sel = IW'(idx);
    #0.1;
    p = int'(cnt_pkts); b = int'(cnt_bytes);
  endtask

  task automatic t_reset;
    int p, b;
    chk("R8 reset res_valid", res_valid, 0);
    chk("R4 reset arp_req", arp_req, 0);
    counts(2, p, b);
    chk("R9 reset pkts", p, 0);
    chk("R9 reset bytes", b, 0);
  endtask

  task automatic t_unwritten;
    look(7, 64);
    chk("R8 valid after request", res_valid, 1);
    chk("R1 unwritten kind drop", res_kind, 0);
    chk("R1 unwritten no tx", res_tx, 0);
    chk("R1 unwritten ifc", res_ifc, 0);
    chk("R1 unwritten hdr", res_hdr, 0);
    chk("R1 unwritten len", res_hdr_len, 0);
    @(negedge clk);
    chk("R8 valid is one cycle", res_valid, 0);
  endtask

  task automatic t_forward;
    wr(1, 3'd1, 0, 9, HA);
    wr(2, 3'd1, 1, 17, HB);
    look(1, 100);
    chk("R2 eth tx", res_tx, 1);
    chk("R2 eth kind", res_kind, 1);
    chk("R2 eth ifc", res_ifc, 9);
    chk("R2 eth hdr", res_hdr, HA);
    chk("R2 eth len 14", res_hdr_len, 14);
    look(2, 100);
    chk("R2 p2p ifc", res_ifc, 17);
    chk("R2 p2p hdr", res_hdr, HB);
    chk("R2 p2p len 4", res_hdr_len, 4);
  endtask

  task automatic t_other_kinds;
    logic [2:0] codes [5] = '{3'd2, 3'd0, 3'd4, 3'd5, 3'd6};
    for (int i = 0; i < 5; i++) begin
      wr(3, codes[i], 0, 11, HC);
      look(3, 40);
      chk(codes[i] == 2 ? "R3 punt code" : "R6 code kept", res_kind, codes[i]);
      chk(codes[i] == 2 ? "R3 punt no tx" : "R6 no tx", res_tx, 0);
      chk("R6 ifc zero", res_ifc, 0);
      chk("R6 hdr zero", res_hdr, 0);
      chk("R6 len zero", res_hdr_len, 0);
      chk("R4 no arp for non-glean", arp_req, 0);
    end
    wr(3, 3'd7, 0, 11, HC);
    look(3, 40);
    chk("R7 code 7 stored as drop", res_kind, 0);
    chk("R7 code 7 no tx", res_tx, 0);
  endtask

  task automatic t_glean;
    int p, b;
    wr(4, 3'd3, 0, 2, HA);
    look(4, 60);
    chk("R4 glean kind", res_kind, 3);
    chk("R4 arp strobe", arp_req, 1);
    chk("R4 arp index", arp_idx, 4);
    chk("R4 glean no tx", res_tx, 0);
    @(negedge clk);
    chk("R4 arp one cycle", arp_req, 0);
    look(5, 30);
    wr(5, 3'd3, 0, 2, HA);
    look(5, 30);
    chk("R5 second glean ignored kind", res_kind, 0);
    chk("R5 second glean no arp", arp_req, 0);
    counts(5, p, b);
    chk("R5 rejected write keeps pkts", p, 2);
    chk("R5 rejected write keeps bytes", b, 60);
    wr(4, 3'd2, 0, 0, 0);
    wr(5, 3'd3, 0, 0, 0);
    look(5, 30);
    chk("R5 freed slot accepts glean", arp_req, 1);
    chk("R5 arp idx new glean", arp_idx, 5);
    look(4, 30);
    chk("R5 old glean now punt", res_kind, 2);
    chk("R4 old glean no arp", arp_req, 0);
  endtask

  task automatic t_counters;
    int p, b;
    wr(1, 3'd1, 0, 9, HA);
    look(1, 60);
    look(1, 200);
    counts(1, p, b);
    chk("R9 pkt count", p, 2);
    chk("R9 byte count", b, 260);
  endtask

  task automatic t_saturate;
    int p, b;
    wr(6, 3'd6, 0, 0, 0);
    for (int i = 0; i < 10; i++) look(6, 100);
    counts(6, p, b);
    chk("R9 pkts before limit", p, 10);
    chk("R9 bytes before limit", b, 1000);
    for (int i = 0; i < 7; i++) look(6, 100);
    counts(6, p, b);
    chk("R10 pkts clamp", p, 15);
    chk("R10 bytes clamp", b, 1023);
    look(6, 5000);
    counts(6, p, b);
    chk("R10 pkts hold", p, 15);
    chk("R10 bytes hold", b, 1023);
  endtask

  task automatic t_rewrite;
    int p, b, p2, b2;
    wr(2, 3'd1, 0, 3, HB);
    look(2, 70);
    counts(1, p, b);
    wr(1, 3'd1, 1, 7, HC);
    look(1, 10);
    chk("R11 new ifc", res_ifc, 7);
    chk("R11 new hdr", res_hdr, HC);
    chk("R11 new len", res_hdr_len, 4);
    counts(1, p2, b2);
    chk("R11 cleared pkts", p2, 1);
    chk("R11 cleared bytes", b2, 10);
    look(2, 0);
    chk("R11 neighbour ifc", res_ifc, 3);
    chk("R11 neighbour len", res_hdr_len, 14);
    counts(2, p2, b2);
    chk("R11 neighbour pkts", p2, 2);
    chk("R11 neighbour bytes", b2, 70);
  endtask

  task automatic t_same_cycle;
    int p, b;
    wr(0, 3'd2, 0, 0, 0);
    look(0, 20);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 0; cfg_kind = 3'd1; cfg_p2p = 0; cfg_ifc = 12; cfg_hdr = HA;
    lk_valid = 1; lk_idx = 0; lk_len = 50;
    @(negedge clk);
    cfg_we = 0; lk_valid = 0;
    chk("R12 old contents returned", res_kind, 2);
    counts(0, p, b);
    chk("R12 pkts cleared", p, 0);
    chk("R12 bytes cleared", b, 0);
    look(0, 8);
    chk("R12 new contents next", res_ifc, 12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_unwritten();
    t_forward();
    t_other_kinds();
    t_glean();
    t_counters();
    t_saturate();
    t_rewrite();
    t_same_cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule